// File: doc/BRIEF.md
# 10-bit Code-Group Decoder with Error Flags

This block sits on the receive side of a serial link, after word alignment. Each cycle in which `validIn` is high, it takes one 10-bit code group per byte lane and turns it into an 8-bit byte and a control flag. The mapping is the standard Gigabit Ethernet 8b/10b code-group table. The block tracks running disparity from one code group to the next. With `LANES = 2` the two lanes form a 16-bit datapath. Disparity runs from lane 0 into lane 1 in the same cycle and then carries into the next accepted word.

For every lane the block reports three separate conditions: an invalid code group, a disparity violation, and a code group taken from the wrong disparity column. A configuration mask can declare some control characters illegal, so a link can reject the control codes its protocol does not use. Two summaries are also produced per lane. One is an error bit that is set on a code or disparity error, for Ethernet-style links. The other is a 3-bit receive status in the PCIe PIPE encoding, in which a code error takes precedence over a disparity error.

Top module: `cg_decoder`

## Requirements
- R1: Lane n takes its word from `codeIn[10n+9:10n]`. Bits 9..4 hold the six-bit sub-block abcdei, with a at bit 9. Bits 3..0 hold fghj, with f at bit 3. A word that is legal in the current disparity column appears one cycle after the accepting edge. The byte HGFEDCBA appears on `dataOut[8n+7:8n]` and `kOut[n]` is high for a control character. `validOut` is high in exactly the cycle after each cycle in which `validIn` is high.
- R2: Running disparity is negative after reset. After each sub-block it becomes positive if the sub-block has more ones than zeros, or if it is 000111 or 0011. It becomes negative if the sub-block has more zeros than ones, or if it is 111000 or 1100. Otherwise it is unchanged. Lane 0 sees the carried disparity, lane 1 sees the disparity after lane 0, and the disparity after the last lane carries into the next accepted word.
- R3: A word that encodes no data byte and no control character, in either column, raises `codeErr` for its lane. When `codeErr` is high, the lane's byte and `kOut` are zero.
- R4: `kMask` bits 0..4 mark K28.0..K28.4 invalid, bits 5..6 mark K28.6..K28.7, and bits 7..10 mark K23.7, K27.7, K29.7 and K30.7. A marked character raises `codeErr` in either column. K28.5 is always legal.
- R5: `wrongCol` is high when the word is a legal, unmasked character in the column for the opposite disparity only. `wrongCol` and `codeErr` are never high together on one lane.
- R6: `dispErr` is high when the six-bit sub-block is unbalanced in the same direction as the disparity entering it, or when the four-bit sub-block is unbalanced in the same direction as the disparity after the six-bit sub-block. This is evaluated for every word, legal or not, so it can coincide with `codeErr`.
- R7: `rxStatus[3n+2:3n]` is 100 on a code error. Otherwise it is 111 on a disparity error, and 000 when neither is present.
- R8: `laneErr[n]` equals `codeErr[n]` OR `dispErr[n]`.
- R9: While `validIn` is low, `validOut` falls on the next cycle. The byte, flag and status outputs hold their values, and the running disparity is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Qualifies `codeIn` this cycle |
| codeIn | input | LANES*10 | Received code groups, lane 0 in the low bits |
| kMask | input | 11 | Control characters declared invalid |
| validOut | output | 1 | Outputs carry a new decoded word |
| dataOut | output | LANES*8 | Decoded bytes |
| kOut | output | LANES | Control-character flag per lane |
| codeErr | output | LANES | Invalid code group per lane |
| dispErr | output | LANES | Disparity violation per lane |
| wrongCol | output | LANES | Legal word from the opposite column per lane |
| laneErr | output | LANES | Code or disparity error per lane |
| rxStatus | output | LANES*3 | PCIe-style receive status per lane |

## Verification
The properties assume that `kMask` changes only together with an accepted word. They also assume that `validIn` and `codeIn` are settled well before each rising edge. The inputs themselves carry no constraint: every 10-bit value is legal stimulus. The bench drives all inputs on the falling edge and changes the mask only alongside a word. It sweeps all 1024 code values on lane 0 while lane 1 gets a scrambled companion, so every column, disparity and masking case is met from whatever disparity the previous words left behind.

// File: rtl/cg_dec_pkg.sv
package cg_dec_pkg;

  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int NUM_K  = 12;
  localparam int MASK_W = NUM_K - 1;
  localparam int STAT_W = 3;

  localparam logic [STAT_W-1:0] ST_OK   = 3'b000;
  localparam logic [STAT_W-1:0] ST_CODE = 3'b100;
  localparam logic [STAT_W-1:0] ST_DISP = 3'b111;

  typedef struct packed {
    logic capture;
  } dec_strobe_t;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              isK;
    logic              codeErr;
    logic              dispErr;
    logic              wrongCol;
  } lane_res_t;

  // six-bit sub-block, negative-disparity column
  function automatic logic [5:0] six_minus(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
      5'd10: return 6'b010101;  5'd11: return 6'b110100;
      5'd12: return 6'b001101;  5'd13: return 6'b101100;
      5'd14: return 6'b011100;  5'd15: return 6'b010111;
      5'd16: return 6'b011011;  5'd17: return 6'b100011;
      5'd18: return 6'b010011;  5'd19: return 6'b110010;
      5'd20: return 6'b001011;  5'd21: return 6'b101010;
      5'd22: return 6'b011010;  5'd23: return 6'b111010;
      5'd24: return 6'b110011;  5'd25: return 6'b100110;
      5'd26: return 6'b010110;  5'd27: return 6'b110110;
      5'd28: return 6'b001110;  5'd29: return 6'b101110;
      5'd30: return 6'b011110;  default: return 6'b101011;
    endcase
  endfunction

  // four-bit sub-block, negative-disparity column
  function automatic logic [3:0] four_minus(input logic [2:0] y, input logic isK, input logic alt7);
    case (y)
      3'd0: return 4'b1011;
      3'd1: return isK ? 4'b0110 : 4'b1001;
      3'd2: return isK ? 4'b1010 : 4'b0101;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return isK ? 4'b0101 : 4'b1010;
      3'd6: return isK ? 4'b1001 : 4'b0110;
      default: return alt7 ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  // returns 1 when disparity is negative after the six-bit sub-block
  function automatic logic rd_after6(input logic [5:0] s, input logic rdNeg);
    if ($countones(s) > 3) return 1'b0;
    if ($countones(s) < 3) return 1'b1;
    if (s == 6'b000111)    return 1'b0;
    if (s == 6'b111000)    return 1'b1;
    return rdNeg;
  endfunction

  function automatic logic rd_after4(input logic [3:0] f, input logic rdNeg);
    if ($countones(f) > 2) return 1'b0;
    if ($countones(f) < 2) return 1'b1;
    if (f == 4'b0011)      return 1'b0;
    if (f == 4'b1100)      return 1'b1;
    return rdNeg;
  endfunction

  function automatic logic [SYM_W-1:0] enc10(input logic [7:0] b, input logic isK, input logic rdNeg);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s;
    logic [3:0] f;
    logic       midNeg;
    logic       alt;
    x = b[4:0];
    y = b[7:5];
    s = (isK && x == 5'd28) ? 6'b001111 : six_minus(x);
    if (!rdNeg && (($countones(s) != 3) || s == 6'b111000)) s = ~s;
    midNeg = rd_after6(s, rdNeg);
    alt = isK || (midNeg && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
          (!midNeg && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    f = four_minus(y, isK, alt);
    if (!midNeg && (isK || ($countones(f) != 2) || f == 4'b1100)) f = ~f;
    return {s, f};
  endfunction

  // control character index 0..11 -> byte value
  function automatic logic [7:0] k_code(input int idx);
    if (idx < 8)   return {3'(idx), 5'd28};
    if (idx == 8)  return 8'hF7;
    if (idx == 9)  return 8'hFB;
    if (idx == 10) return 8'hFD;
    return 8'hFE;
  endfunction

  function automatic logic k_masked(input int idx, input logic [MASK_W-1:0] m);
    if (idx == 5) return 1'b0;
    return m[4'((idx < 5) ? idx : idx - 1)];
  endfunction

endpackage

// File: rtl/cg_sym_lookup.sv
module cg_sym_lookup
  import cg_dec_pkg::*;
(
  input  logic [SYM_W-1:0]  symIn,
  input  logic              rdNegIn,
  input  logic [MASK_W-1:0] kMask,
  output lane_res_t         res,
  output logic              rdNegOut
);

  logic              hitRight;
  logic              hitWrong;
  logic              hitMasked;
  logic              hitK;
  logic [BYTE_W-1:0] hitByte;
  logic              midNeg;
  logic              badCode;

  always_comb begin
    hitRight  = 1'b0;
    hitWrong  = 1'b0;
    hitMasked = 1'b0;
    hitK      = 1'b0;
    hitByte   = '0;
    for (int v = 0; v < 256; v++) begin
      if (enc10(8'(v), 1'b0, rdNegIn) == symIn) begin
        hitRight = 1'b1;
        hitByte  = 8'(v);
      end else if (enc10(8'(v), 1'b0, !rdNegIn) == symIn) begin
        hitWrong = 1'b1;
        hitByte  = 8'(v);
      end
    end
    for (int k = 0; k < NUM_K; k++) begin
      if (enc10(k_code(k), 1'b1, rdNegIn) == symIn) begin
        hitRight  = 1'b1;
        hitByte   = k_code(k);
        hitK      = 1'b1;
        hitMasked = k_masked(k, kMask);
      end else if (enc10(k_code(k), 1'b1, !rdNegIn) == symIn) begin
        hitWrong  = 1'b1;
        hitByte   = k_code(k);
        hitK      = 1'b1;
        hitMasked = k_masked(k, kMask);
      end
    end
  end

  assign badCode = !(hitRight || hitWrong) || hitMasked;
  assign midNeg  = rd_after6(symIn[9:4], rdNegIn);

  always_comb begin
    res.codeErr  = badCode;
    res.wrongCol = hitWrong && !hitRight && !badCode;
    res.data     = badCode ? '0 : hitByte;
    res.isK      = !badCode && hitK;
    res.dispErr  = (rdNegIn && ($countones(symIn[9:4]) < 3)) ||
                   (!rdNegIn && ($countones(symIn[9:4]) > 3)) ||
                   (midNeg && ($countones(symIn[3:0]) < 2)) ||
                   (!midNeg && ($countones(symIn[3:0]) > 2));
  end

  assign rdNegOut = rd_after4(symIn[3:0], midNeg);

endmodule

// File: rtl/cg_dec_datapath.sv
module cg_dec_datapath
  import cg_dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dec_strobe_t             strobe,
  input  logic [LANES*SYM_W-1:0]  symIn,
  input  logic [MASK_W-1:0]       kMask,
  output logic [LANES*BYTE_W-1:0] dataOut,
  output logic [LANES-1:0]        kOut,
  output logic [LANES-1:0]        codeErr,
  output logic [LANES-1:0]        dispErr,
  output logic [LANES-1:0]        wrongCol,
  output logic [LANES-1:0]        laneErr,
  output logic [LANES*STAT_W-1:0] rxStatus
);

  logic           rdNegQ;
  logic [LANES:0] rdChain;
  lane_res_t      laneRes [LANES];

  assign rdChain[0] = rdNegQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cg_sym_lookup u_lookup (
      .symIn    (symIn[g*SYM_W +: SYM_W]),
      .rdNegIn  (rdChain[g]),
      .kMask    (kMask),
      .res      (laneRes[g]),
      .rdNegOut (rdChain[g+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdNegQ   <= 1'b1;
      dataOut  <= '0;
      kOut     <= '0;
      codeErr  <= '0;
      dispErr  <= '0;
      wrongCol <= '0;
      laneErr  <= '0;
      rxStatus <= '0;
    end else if (strobe.capture) begin
      rdNegQ <= rdChain[LANES];
      for (int i = 0; i < LANES; i++) begin
        dataOut[i*BYTE_W +: BYTE_W] <= laneRes[i].data;
        kOut[i]     <= laneRes[i].isK;
        codeErr[i]  <= laneRes[i].codeErr;
        dispErr[i]  <= laneRes[i].dispErr;
        wrongCol[i] <= laneRes[i].wrongCol;
        laneErr[i]  <= laneRes[i].codeErr | laneRes[i].dispErr;
        rxStatus[i*STAT_W +: STAT_W] <= laneRes[i].codeErr ? ST_CODE :
                                        (laneRes[i].dispErr ? ST_DISP : ST_OK);
      end
    end
  end

endmodule

// File: rtl/cg_dec_ctrl.sv
module cg_dec_ctrl
  import cg_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  output dec_strobe_t strobe,
  output logic        validOut
);

  assign strobe.capture = validIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/cg_decoder.sv
module cg_decoder
  import cg_dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    validIn,
  input  logic [LANES*SYM_W-1:0]  codeIn,
  input  logic [MASK_W-1:0]       kMask,
  output logic                    validOut,
  output logic [LANES*BYTE_W-1:0] dataOut,
  output logic [LANES-1:0]        kOut,
  output logic [LANES-1:0]        codeErr,
  output logic [LANES-1:0]        dispErr,
  output logic [LANES-1:0]        wrongCol,
  output logic [LANES-1:0]        laneErr,
  output logic [LANES*STAT_W-1:0] rxStatus
);

  dec_strobe_t strobe;

  cg_dec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  cg_dec_datapath #(.LANES(LANES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .symIn    (codeIn),
    .kMask    (kMask),
    .dataOut  (dataOut),
    .kOut     (kOut),
    .codeErr  (codeErr),
    .dispErr  (dispErr),
    .wrongCol (wrongCol),
    .laneErr  (laneErr),
    .rxStatus (rxStatus)
  );

endmodule

// File: rtl/cg_decoder_chk.sv
module cg_decoder_chk #(
  parameter int LANES = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               validIn,
  input logic               validOut,
  input logic [LANES*8-1:0] dataOut,
  input logic [LANES-1:0]   kOut,
  input logic [LANES-1:0]   codeErr,
  input logic [LANES-1:0]   dispErr,
  input logic [LANES-1:0]   wrongCol,
  input logic [LANES-1:0]   laneErr,
  input logic [LANES*3-1:0] rxStatus
);

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!validOut && $stable(dataOut) && $stable(codeErr) && $stable(rxStatus)));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R5
    col_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(codeErr[g] && wrongCol[g]));

    // R3
    code_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      codeErr[g] |-> (dataOut[g*8 +: 8] == 8'd0 && !kOut[g]));

    // R7
    stat_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      codeErr[g] |-> rxStatus[g*3 +: 3] == 3'b100);

    // R7
    stat_disp_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!codeErr[g] && dispErr[g]) |-> rxStatus[g*3 +: 3] == 3'b111);

    // R7
    stat_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!codeErr[g] && !dispErr[g]) |-> rxStatus[g*3 +: 3] == 3'b000);

    // R8
    lane_err_chk: assert property (@(posedge clk) disable iff (!rstN)
      laneErr[g] == (codeErr[g] || dispErr[g]));
  end

endmodule

bind cg_decoder cg_decoder_chk #(.LANES(LANES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .validOut (validOut),
  .dataOut  (dataOut),
  .kOut     (kOut),
  .codeErr  (codeErr),
  .dispErr  (dispErr),
  .wrongCol (wrongCol),
  .laneErr  (laneErr),
  .rxStatus (rxStatus)
);

// File: tb/cg_decoder_tb_top.sv
`timescale 1ns/1ps
module cg_decoder_tb_top;

  localparam int LANES = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [19:0] codeIn = '0;
  logic [10:0] kMask = '0;
  logic        validOut;
  logic [15:0] dataOut;
  logic [1:0]  kOut, codeErr, dispErr, wrongCol, laneErr;
  logic [5:0]  rxStatus;

  cg_decoder #(.LANES(LANES)) dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .codeIn(codeIn), .kMask(kMask),
    .validOut(validOut), .dataOut(dataOut), .kOut(kOut), .codeErr(codeErr),
    .dispErr(dispErr), .wrongCol(wrongCol), .laneErr(laneErr), .rxStatus(rxStatus)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic        rdNeg = 1'b1;
  logic        eValid = 1'b0;
  logic [7:0]  eData [2];
  logic        eK [2], eCe [2], eDe [2], eWc [2];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // both disparity columns: {negative, positive}
  function automatic logic [11:0] six_pair(input logic [4:0] x);
    case (x)
      5'd0:  return 12'b100111_011000; 5'd1:  return 12'b011101_100010;
      5'd2:  return 12'b101101_010010; 5'd3:  return 12'b110001_110001;
      5'd4:  return 12'b110101_001010; 5'd5:  return 12'b101001_101001;
      5'd6:  return 12'b011001_011001; 5'd7:  return 12'b111000_000111;
      5'd8:  return 12'b111001_000110; 5'd9:  return 12'b100101_100101;
      5'd10: return 12'b010101_010101; 5'd11: return 12'b110100_110100;
      5'd12: return 12'b001101_001101; 5'd13: return 12'b101100_101100;
      5'd14: return 12'b011100_011100; 5'd15: return 12'b010111_101000;
      5'd16: return 12'b011011_100100; 5'd17: return 12'b100011_100011;
      5'd18: return 12'b010011_010011; 5'd19: return 12'b110010_110010;
      5'd20: return 12'b001011_001011; 5'd21: return 12'b101010_101010;
      5'd22: return 12'b011010_011010; 5'd23: return 12'b111010_000101;
      5'd24: return 12'b110011_001100; 5'd25: return 12'b100110_100110;
      5'd26: return 12'b010110_010110; 5'd27: return 12'b110110_001001;
      5'd28: return 12'b001110_001110; 5'd29: return 12'b101110_010001;
      5'd30: return 12'b011110_100001; default: return 12'b101011_010100;
    endcase
  endfunction

  function automatic logic [7:0] four_pair(input logic [2:0] y, input logic isK, input logic alt);
    if (isK) case (y)
      3'd0: return 8'b1011_0100; 3'd1: return 8'b0110_1001;
      3'd2: return 8'b1010_0101; 3'd3: return 8'b1100_0011;
      3'd4: return 8'b1101_0010; 3'd5: return 8'b0101_1010;
      3'd6: return 8'b1001_0110; default: return 8'b0111_1000;
    endcase
    case (y)
      3'd0: return 8'b1011_0100; 3'd1: return 8'b1001_1001;
      3'd2: return 8'b0101_0101; 3'd3: return 8'b1100_0011;
      3'd4: return 8'b1101_0010; 3'd5: return 8'b1010_1010;
      3'd6: return 8'b0110_0110; default: return alt ? 8'b0111_1000 : 8'b1110_0001;
    endcase
  endfunction

  function automatic logic next_neg(input int ones, input int half, input logic upPat,
                                    input logic dnPat, input logic neg);
    if (ones > half) return 1'b0;
    if (ones < half) return 1'b1;
    if (upPat) return 1'b0;
    if (dnPat) return 1'b1;
    return neg;
  endfunction

  function automatic logic [9:0] benc(input logic [7:0] b, input logic isK, input logic neg);
    logic [11:0] p6;
    logic [5:0]  s;
    logic [7:0]  p4;
    logic        mid, alt;
    int          x;
    x = int'(b[4:0]);
    p6 = (isK && x == 28) ? 12'b001111_110000 : six_pair(b[4:0]);
    s = neg ? p6[11:6] : p6[5:0];
    mid = next_neg($countones(s), 3, s == 6'b000111, s == 6'b111000, neg);
    alt = mid ? (x == 17 || x == 18 || x == 20) : (x == 11 || x == 13 || x == 14);
    p4 = four_pair(b[7:5], isK, alt);
    return {s, mid ? p4[7:4] : p4[3:0]};
  endfunction

  function automatic logic [7:0] kbyte(input int i);
    case (i)
      8: return 8'hF7; 9: return 8'hFB; 10: return 8'hFD; 11: return 8'hFE;
      default: return {3'(i), 5'd28};
    endcase
  endfunction

  function automatic logic kmasked(input int i, input logic [10:0] m);
    if (i == 5) return 1'b0;
    if (i < 5) return m[i];
    return m[i-1];
  endfunction

  task automatic model(input logic [9:0] w, input logic neg, input logic [10:0] m,
                       output logic [7:0] d, output logic k, output logic ce,
                       output logic de, output logic wc, output logic nOut);
    logic right, wrong, msk, isK, mid;
    logic [7:0] byt;
    right = 0; wrong = 0; msk = 0; isK = 0; byt = 0;
    for (int v = 0; v < 256; v++) begin
      if (benc(8'(v), 1'b0, neg) == w) begin right = 1; byt = 8'(v); end
      else if (benc(8'(v), 1'b0, !neg) == w) begin wrong = 1; byt = 8'(v); end
    end
    for (int i = 0; i < 12; i++) begin
      if (benc(kbyte(i), 1'b1, neg) == w || benc(kbyte(i), 1'b1, !neg) == w) begin
        if (benc(kbyte(i), 1'b1, neg) == w) right = 1; else wrong = 1;
        byt = kbyte(i); isK = 1; msk = kmasked(i, m);
      end
    end
    ce = !(right || wrong) || msk;
    wc = wrong && !right && !ce;
    d  = ce ? 8'd0 : byt;
    k  = !ce && isK;
    mid = next_neg($countones(w[9:4]), 3, w[9:4] == 6'b000111, w[9:4] == 6'b111000, neg);
    de = (neg && $countones(w[9:4]) < 3) || (!neg && $countones(w[9:4]) > 3) ||
         (mid && $countones(w[3:0]) < 2) || (!mid && $countones(w[3:0]) > 2);
    nOut = next_neg($countones(w[3:0]), 2, w[3:0] == 4'b0011, w[3:0] == 4'b1100, mid);
  endtask

  task automatic verify(input string phase);
    logic [2:0] st;
    check({"R9 validOut ", phase}, {31'd0, validOut}, {31'd0, eValid});
    for (int l = 0; l < 2; l++) begin
      st = eCe[l] ? 3'b100 : (eDe[l] ? 3'b111 : 3'b000);
      check({"R1 byte ", phase}, {23'd0, kOut[l], dataOut[l*8 +: 8]}, {23'd0, eK[l], eData[l]});
      check({"R3 codeErr ", phase}, {31'd0, codeErr[l]}, {31'd0, eCe[l]});
      check({"R5 wrongCol ", phase}, {31'd0, wrongCol[l]}, {31'd0, eWc[l]});
      check({"R6 dispErr ", phase}, {31'd0, dispErr[l]}, {31'd0, eDe[l]});
      check({"R7 rxStatus ", phase}, {29'd0, rxStatus[l*3 +: 3]}, {29'd0, st});
      check({"R8 laneErr ", phase}, {31'd0, laneErr[l]}, {31'd0, eCe[l] | eDe[l]});
    end
  endtask

  task automatic apply(input logic v, input logic [9:0] w0, input logic [9:0] w1,
                       input logic [10:0] m, input string phase);
    logic n1, n2;
    @(negedge clk);
    verify(phase);
    validIn = v;
    codeIn  = {w1, w0};
    kMask   = m;
    eValid  = v;
    if (v) begin
      model(w0, rdNeg, m, eData[0], eK[0], eCe[0], eDe[0], eWc[0], n1);
      model(w1, n1, m, eData[1], eK[1], eCe[1], eDe[1], eWc[1], n2);
      rdNeg = n2;
    end
  endtask

  // encodes b on lane 0 with the bench disparity (flip selects the wrong column)
  task automatic send_pair(input logic [7:0] b0, input logic k0, input logic flip0,
                           input logic [7:0] b1, input logic k1,
                           input logic [10:0] m, input string phase);
    logic [9:0] w0, w1;
    logic [7:0] d; logic k, ce, de, wc, n1;
    w0 = benc(b0, k0, rdNeg ^ flip0);
    model(w0, rdNeg, m, d, k, ce, de, wc, n1);
    w1 = benc(b1, k1, n1);
    apply(1'b1, w0, w1, m, phase);
  endtask

  bit done = 0;

  initial begin
    for (int l = 0; l < 2; l++) begin
      eData[l] = 0; eK[l] = 0; eCe[l] = 0; eDe[l] = 0; eWc[l] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state, then first word must be read with negative disparity
    send_pair(8'hBC, 1'b1, 1'b0, 8'h4A, 1'b0, 11'd0, "R2 reset");

    // R1 R2: every data byte in the correct column, idle gaps for R9
    for (int b = 0; b < 256; b++) begin
      send_pair(8'(b), 1'b0, 1'b0, 8'(b) ^ 8'hA5, 1'b0, 11'd0, "R1 data sweep");
      if (b % 16 == 15) apply(1'b0, 10'(b * 7), 10'(b * 3), 11'd0, "R9 idle");
    end

    // R4: each mask bit against every control character
    for (int j = 0; j <= 11; j++) begin
      for (int i = 0; i < 12; i++) begin
        send_pair(kbyte(i), 1'b1, 1'b0, kbyte((i + 5) % 12), 1'b1,
                  (j == 11) ? 11'h7FF : 11'(1 << j), "R4 mask sweep");
      end
    end
    for (int i = 0; i < 12; i++)
      send_pair(kbyte(i), 1'b1, 1'b0, 8'hBC, 1'b1, 11'd0, "R4 unmasked");

    // R5: data bytes sent from the opposite column on lane 0
    for (int b = 0; b < 256; b++)
      send_pair(8'(b), 1'b0, 1'b1, 8'(b + 3), 1'b0, 11'd0, "R5 wrong column");

    // R3 R6: every 10-bit value on lane 0, scrambled companion on lane 1
    for (int w = 0; w < 1024; w++)
      apply(1'b1, 10'(w), 10'((w * 37 + 11) % 1024), 11'h2A5, "R3 R6 exhaustive");

    apply(1'b0, 10'h3FF, 10'h000, 11'd0, "R9 flush");
    apply(1'b0, 10'h155, 10'h2AA, 11'd0, "R9 flush");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule